// File: doc/BRIEF.md
# Paravirtual Device Register File

This block is the common register header of a legacy paravirtual device that sits behind a byte-addressed I/O window. The driver uses it to read the device's offered features and store the ones it accepts, to pick one of a fixed set of queues and program that queue's base page and interrupt vector, to ring a doorbell that names a queue, to walk the device status through its bring-up, and to acknowledge interrupts by reading an interrupt status byte that clears itself when read.

Accesses that fall past the header are passed through, combinationally, to a device-specific configuration window on a separate port with the address rebased to zero. The header is 20 bytes long when message interrupts are off and 24 bytes long when they are on, because two vector registers then occupy offsets 20 and 22. The block drives a level interrupt for the legacy path, a one-cycle doorbell strobe carrying the queue index, and a one-cycle device-reset pulse whenever the driver requests a reset through a zero write.

Top module: `pvd_regfile`

## Requirements
- R1: After reset the guest feature, queue select, status and interrupt status registers read zero, every queue page reads zero, and the config and queue vectors read 0xFFFF; intx, notify_stb and dev_reset are low.
- R2: Offset 0 reads host_feat and ignores writes. Offset 4 stores the written word, except that a word with bit 30 set stores fallback_mask AND host_feat instead.
- R3: A write to offset 14 whose low 16 bits are below NUM_QUEUES selects that queue; any larger value is ignored and the old selection stays. Offset 14 reads the selection.
- R4: A non-zero write to offset 8 stores the page number for the selected queue only and offset 8 reads it back; offset 12 reads the selected queue's size from q_size (16 bits per queue, queue 0 lowest) and ignores writes.
- R5: Writing zero to offset 8, or a status byte of zero to offset 18, resets the device: every register of R1 returns to its reset value, intx drops, and dev_reset is high for exactly the one cycle after the write.
- R6: A write to offset 16 raises notify_stb for the one cycle after the write, with notify_idx equal to the low 16 bits written.
- R7: Reading offset 19 returns the interrupt status byte and clears it in the same access; isr_set bits are ORed in each cycle. intx equals interrupt status bit 0 while msg_en is low and is low while msg_en is high.
- R8: With msg_en high, offset 20 holds the config vector and offset 22 the selected queue's vector; a written value below cfg_nvec is stored, any other value stores 0xFFFF.
- R9: Offsets at or above the header length (20 with msg_en low, 24 with it high) go to the window: dev_en is high, dev_addr is the offset minus the header length, dev_wr and dev_wdata follow the access, and acc_rdata returns dev_rdata.
- R10: A read of any other header offset (including 16) returns 0xFFFFFFFF; a write to any other header offset changes nothing.
- R11: A status write with bit 2 (driver ready) set while bm_en is low sets a sticky workaround flag cleared only by rst_n. A command write with cmd_bm low clears status bit 2 when the flag is clear and leaves it alone when the flag is set.
- R12: A write to offset 18 stores the low 8 bits of the written word as status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_en | input | 1 | Message interrupts enabled; sets header length and vector register visibility |
| host_feat | input | 32 | Features offered by the device |
| fallback_mask | input | 32 | Features kept when the driver flags a failed negotiation; zero for none |
| cfg_nvec | input | 16 | Number of interrupt vectors available |
| q_size | input | 16*NUM_QUEUES | Size of each queue, queue 0 in the lowest bits |
| acc_en | input | 1 | Register access this cycle |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | ADDR_W | Byte offset into the I/O window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid during a read access |
| dev_en | output | 1 | Access falls into the device-specific window |
| dev_wr | output | 1 | Window access is a write |
| dev_addr | output | ADDR_W | Rebased window offset |
| dev_wdata | output | 32 | Window write data |
| dev_rdata | input | 32 | Window read data |
| isr_set | input | 8 | Interrupt status bits to raise |
| bm_en | input | 1 | Current bus-master enable state |
| cmd_wr | input | 1 | Command register is being written |
| cmd_bm | input | 1 | Bus-master bit of that command write |
| intx | output | 1 | Legacy level interrupt |
| notify_stb | output | 1 | Doorbell strobe |
| notify_idx | output | 16 | Queue index of the doorbell |
| dev_reset | output | 1 | One-cycle device reset pulse |

## Verification
The bench sweeps every offset of the window in both interrupt modes against an arithmetic model, so a design that placed the window at the wrong header length, returned a stale register for the notify or odd offsets, or rebased the window address wrongly would show a mismatch on some offset. It walks queue selections past the queue count, where a design that stored out-of-range selections would expose the wrong page or size, and vector values around cfg_nvec, where an off-by-one would store a vector that should read 0xFFFF. It triggers both kinds of zero-write reset with state present and checks that all registers, intx and the one-cycle dev_reset pulse behave; a design that forgot the vectors or the interrupt byte would read them back non-reset. The bus-master flag is driven in both orders, so a design that cleared driver ready despite the flag, or never set the flag, reads back the wrong status.

// File: rtl/pvd_pkg.sv
// Shared constants and the register-select type of the paravirtual
// device register file. Offsets are fixed by the driver ABI.
package pvd_pkg;

    localparam int OFF_HOST_FEAT  = 0;
    localparam int OFF_GUEST_FEAT = 4;
    localparam int OFF_QPAGE      = 8;
    localparam int OFF_QSIZE      = 12;
    localparam int OFF_QSEL       = 14;
    localparam int OFF_NOTIFY     = 16;
    localparam int OFF_STATUS     = 18;
    localparam int OFF_ISR        = 19;
    localparam int OFF_CFG_VEC    = 20;
    localparam int OFF_QUEUE_VEC  = 22;

    localparam int HDR_LEN_PLAIN  = 20;
    localparam int HDR_LEN_MSG    = 24;

    localparam logic [15:0] NO_VECTOR  = 16'hFFFF;
    localparam logic [31:0] UNMAPPED   = 32'hFFFF_FFFF;
    localparam int          DRV_OK_BIT = 2;
    localparam int          BAD_FEAT_BIT = 30;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_HOSTF,
        SEL_GUESTF,
        SEL_QPAGE,
        SEL_QSIZE,
        SEL_QSEL,
        SEL_NOTIFY,
        SEL_STATUS,
        SEL_ISR,
        SEL_CFGVEC,
        SEL_QVEC,
        SEL_WINDOW
    } reg_sel_e;

endpackage

// File: rtl/pvd_addr_dec.sv
// Address decoder: maps a byte offset to a header register or to the
// device-specific window, and rebases window offsets to zero.
// Assumes only exact register offsets hit; every other header offset
// decodes to SEL_NONE.
module pvd_addr_dec
    import pvd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              msg_en,
    output reg_sel_e          sel,
    output logic [ADDR_W-1:0] win_addr
);
    localparam logic [ADDR_W-1:0] A_HOSTF  = ADDR_W'(OFF_HOST_FEAT);
    localparam logic [ADDR_W-1:0] A_GUESTF = ADDR_W'(OFF_GUEST_FEAT);
    localparam logic [ADDR_W-1:0] A_QPAGE  = ADDR_W'(OFF_QPAGE);
    localparam logic [ADDR_W-1:0] A_QSIZE  = ADDR_W'(OFF_QSIZE);
    localparam logic [ADDR_W-1:0] A_QSEL   = ADDR_W'(OFF_QSEL);
    localparam logic [ADDR_W-1:0] A_NOTIFY = ADDR_W'(OFF_NOTIFY);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_ISR    = ADDR_W'(OFF_ISR);
    localparam logic [ADDR_W-1:0] A_CFGVEC = ADDR_W'(OFF_CFG_VEC);
    localparam logic [ADDR_W-1:0] A_QVEC   = ADDR_W'(OFF_QUEUE_VEC);
    localparam logic [ADDR_W-1:0] H_PLAIN  = ADDR_W'(HDR_LEN_PLAIN);
    localparam logic [ADDR_W-1:0] H_MSG    = ADDR_W'(HDR_LEN_MSG);

    logic [ADDR_W-1:0] hdr_len;

    // Header length depends on whether the vector registers are present.
    assign hdr_len  = msg_en ? H_MSG : H_PLAIN;
    assign win_addr = addr - hdr_len;

    // Select the register addressed; window wins above the header.
    always_comb begin
        sel = SEL_NONE;
        if (addr >= hdr_len) begin
            sel = SEL_WINDOW;
        end else begin
            case (addr)
                A_HOSTF:  sel = SEL_HOSTF;
                A_GUESTF: sel = SEL_GUESTF;
                A_QPAGE:  sel = SEL_QPAGE;
                A_QSIZE:  sel = SEL_QSIZE;
                A_QSEL:   sel = SEL_QSEL;
                A_NOTIFY: sel = SEL_NOTIFY;
                A_STATUS: sel = SEL_STATUS;
                A_ISR:    sel = SEL_ISR;
                A_CFGVEC: sel = SEL_CFGVEC;
                A_QVEC:   sel = SEL_QVEC;
                default:  sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pvd_queue_bank.sv
// Per-queue storage: base page number and interrupt vector for each of
// NUM_QUEUES queues. Writes go to the queue named by qsel; the caller
// has already filtered zero pages and resolved failed vectors.
module pvd_queue_bank
    import pvd_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    parameter int QSEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [QSEL_W-1:0] qsel,
    input  logic              page_we,
    input  logic [31:0]       page_wdata,
    input  logic              vec_we,
    input  logic [15:0]       vec_wdata,
    output logic [31:0]       page_rd,
    output logic [15:0]       vec_rd
);
    logic [31:0] page_q [NUM_QUEUES];
    logic [15:0] vec_q  [NUM_QUEUES];

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
        // Hold one queue's page and vector; device reset clears both.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                page_q[q] <= '0;
                vec_q[q]  <= NO_VECTOR;
            end else begin
                if (page_we && (32'(qsel) == q)) page_q[q] <= page_wdata;
                if (vec_we  && (32'(qsel) == q)) vec_q[q]  <= vec_wdata;
            end
        end

        // R4
        page_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (page_we && !soft_rst && (32'(qsel) == q)) |=> (page_q[q] == $past(page_wdata)));

        // R5
        queue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst |=> ((page_q[q] == '0) && (vec_q[q] == NO_VECTOR)));
    end

    // Present the selected queue's state for reads.
    assign page_rd = page_q[qsel];
    assign vec_rd  = vec_q[qsel];

endmodule

// File: rtl/pvd_isr.sv
// Interrupt status byte with read-to-clear and the legacy level output.
// Assumes a read clear and newly raised bits in the same cycle keep the
// new bits; a device reset drops everything.
module pvd_isr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic [7:0] set_bits,
    input  logic       rd_clr,
    input  logic       msg_en,
    output logic [7:0] isr_q,
    output logic       intx
);
    // Accumulate raised bits; a read or a device reset empties the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) isr_q <= '0;
        else                    isr_q <= (rd_clr ? 8'h00 : isr_q) | set_bits;
    end

    // Legacy line follows bit 0 only when message interrupts are off.
    assign intx = !msg_en && isr_q[0];

    // R7
    isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !soft_rst) |=> (isr_q == $past(set_bits)));

endmodule

// File: rtl/pvd_regfile.sv
// Common register header of a legacy paravirtual device behind a
// byte-addressed I/O window. Reads are combinational within the access
// cycle; writes and read side effects take effect at the clock edge.
// Assumes cfg_nvec is static while the device is in use.
module pvd_regfile
    import pvd_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    parameter int ADDR_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msg_en,
    input  logic [31:0]             host_feat,
    input  logic [31:0]             fallback_mask,
    input  logic [15:0]             cfg_nvec,
    input  logic [16*NUM_QUEUES-1:0] q_size,
    input  logic                    acc_en,
    input  logic                    acc_wr,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [31:0]             acc_wdata,
    output logic [31:0]             acc_rdata,
    output logic                    dev_en,
    output logic                    dev_wr,
    output logic [ADDR_W-1:0]       dev_addr,
    output logic [31:0]             dev_wdata,
    input  logic [31:0]             dev_rdata,
    input  logic [7:0]              isr_set,
    input  logic                    bm_en,
    input  logic                    cmd_wr,
    input  logic                    cmd_bm,
    output logic                    intx,
    output logic                    notify_stb,
    output logic [15:0]             notify_idx,
    output logic                    dev_reset
);
    localparam int QSEL_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
    localparam logic [ADDR_W-1:0] A_NOTIFY = ADDR_W'(OFF_NOTIFY);

    reg_sel_e          sel;
    logic [ADDR_W-1:0] win_addr;
    logic              wr_hit, rd_hit, soft_rst, page_we, qvec_we, isr_rd;
    logic [15:0]       vec_val;
    logic [31:0]       gf_new;
    logic [31:0]       gf_q;
    logic [QSEL_W-1:0] qsel_q;
    logic [7:0]        status_q;
    logic              bug_q;
    logic [15:0]       cvec_q;
    logic [31:0]       page_rd;
    logic [15:0]       qvec_rd;
    logic [7:0]        isr_q;
    logic [15:0]       qsize_arr [NUM_QUEUES];

    pvd_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (acc_addr),
        .msg_en   (msg_en),
        .sel      (sel),
        .win_addr (win_addr)
    );

    // Unpack the per-queue sizes for indexed reads.
    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_qsize
        assign qsize_arr[q] = q_size[q*16 +: 16];
    end

    // Access qualification and write side conditions.
    assign wr_hit   = acc_en && acc_wr;
    assign rd_hit   = acc_en && !acc_wr;
    assign isr_rd   = rd_hit && (sel == SEL_ISR);
    assign soft_rst = wr_hit && (((sel == SEL_QPAGE) && (acc_wdata == '0)) ||
                                 ((sel == SEL_STATUS) && (acc_wdata[7:0] == 8'h00)));
    assign page_we  = wr_hit && (sel == SEL_QPAGE) && (acc_wdata != '0);
    assign qvec_we  = wr_hit && (sel == SEL_QVEC);
    assign vec_val  = (acc_wdata[15:0] < cfg_nvec) ? acc_wdata[15:0] : NO_VECTOR;
    assign gf_new   = acc_wdata[BAD_FEAT_BIT] ? (fallback_mask & host_feat) : acc_wdata;

    pvd_queue_bank #(.NUM_QUEUES(NUM_QUEUES), .QSEL_W(QSEL_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .qsel       (qsel_q),
        .page_we    (page_we),
        .page_wdata (acc_wdata),
        .vec_we     (qvec_we),
        .vec_wdata  (vec_val),
        .page_rd    (page_rd),
        .vec_rd     (qvec_rd)
    );

    pvd_isr u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .set_bits (isr_set),
        .rd_clr   (isr_rd),
        .msg_en   (msg_en),
        .isr_q    (isr_q),
        .intx     (intx)
    );

    // Guest feature register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                   gf_q <= '0;
        else if (wr_hit && (sel == SEL_GUESTF))   gf_q <= gf_new;
    end

    // Queue selector; out-of-range selections are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            qsel_q <= '0;
        end else if (wr_hit && (sel == SEL_QSEL) &&
                     (32'(acc_wdata[15:0]) < NUM_QUEUES)) begin
            qsel_q <= QSEL_W'(acc_wdata[15:0]);
        end
    end

    // Device status; the bus-master workaround may clear driver ready.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            status_q <= '0;
        else if (wr_hit && (sel == SEL_STATUS))
            status_q <= acc_wdata[7:0];
        else if (cmd_wr && !cmd_bm && !bug_q)
            status_q[DRV_OK_BIT] <= 1'b0;
    end

    // Sticky flag for drivers that go ready without bus mastering.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bug_q <= 1'b0;
        else if (wr_hit && (sel == SEL_STATUS) && acc_wdata[DRV_OK_BIT] && !bm_en)
            bug_q <= 1'b1;
    end

    // Config-change vector.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                   cvec_q <= NO_VECTOR;
        else if (wr_hit && (sel == SEL_CFGVEC))   cvec_q <= vec_val;
    end

    // Doorbell strobe and the one-cycle reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_stb <= 1'b0;
            notify_idx <= '0;
            dev_reset  <= 1'b0;
        end else begin
            notify_stb <= wr_hit && (sel == SEL_NOTIFY);
            if (wr_hit && (sel == SEL_NOTIFY)) notify_idx <= acc_wdata[15:0];
            dev_reset  <= soft_rst;
        end
    end

    // Window pass-through.
    assign dev_en    = acc_en && (sel == SEL_WINDOW);
    assign dev_wr    = acc_wr;
    assign dev_addr  = win_addr;
    assign dev_wdata = acc_wdata;

    // Read data multiplexer.
    always_comb begin
        case (sel)
            SEL_HOSTF:  acc_rdata = host_feat;
            SEL_GUESTF: acc_rdata = gf_q;
            SEL_QPAGE:  acc_rdata = page_rd;
            SEL_QSIZE:  acc_rdata = {16'h0000, qsize_arr[qsel_q]};
            SEL_QSEL:   acc_rdata = 32'(qsel_q);
            SEL_STATUS: acc_rdata = {24'h0, status_q};
            SEL_ISR:    acc_rdata = {24'h0, isr_q};
            SEL_CFGVEC: acc_rdata = {16'h0000, cvec_q};
            SEL_QVEC:   acc_rdata = {16'h0000, qvec_rd};
            SEL_WINDOW: acc_rdata = dev_rdata;
            default:    acc_rdata = UNMAPPED;
        endcase
    end

    // R3
    qsel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(qsel_q) < NUM_QUEUES);

    // R6
    notify_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        notify_stb |-> $past(acc_en && acc_wr && (acc_addr == A_NOTIFY)));

    // R5
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> ((status_q == '0) && (gf_q == '0) && (qsel_q == '0) && (isr_q == '0)));

    // R8
    cvec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cvec_q == NO_VECTOR) || (cvec_q < cfg_nvec));

    // R11
    bm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_bm && !bug_q && !(wr_hit && (sel == SEL_STATUS))) |=> !status_q[DRV_OK_BIT]);

endmodule

// File: tb/test_pvd_regfile.sv
module test_pvd_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NQ   = 4;
    localparam int AW   = 8;
    localparam int NVEC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_en = 1'b0;
    logic [31:0] host_feat = 32'h7100_00F3;
    logic [31:0] fallback_mask = 32'h0F0F_00FF;
    logic [15:0] cfg_nvec = 16'(NVEC);
    logic [16*NQ-1:0] q_size;
    logic acc_en = 1'b0, acc_wr = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic dev_en, dev_wr;
    logic [AW-1:0] dev_addr;
    logic [31:0] dev_wdata, dev_rdata;
    logic [7:0] isr_set = '0;
    logic bm_en = 1'b1, cmd_wr = 1'b0, cmd_bm = 1'b1;
    logic intx, notify_stb, dev_reset;
    logic [15:0] notify_idx;

    int checks = 0;
    int errors = 0;

    for (genvar g = 0; g < NQ; g++) begin : g_qs
        assign q_size[g*16 +: 16] = 16'(64 * (g + 1));
    end
    assign dev_rdata = 32'hC0DE_0000 | 32'(dev_addr);

    always #(CLK_PERIOD/2) clk = ~clk;

    pvd_regfile #(.NUM_QUEUES(NQ), .ADDR_W(AW)) i_pvd_regfile (
        .clk(clk), .rst_n(rst_n), .msg_en(msg_en), .host_feat(host_feat),
        .fallback_mask(fallback_mask), .cfg_nvec(cfg_nvec), .q_size(q_size),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .dev_en(dev_en), .dev_wr(dev_wr), .dev_addr(dev_addr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .isr_set(isr_set), .bm_en(bm_en),
        .cmd_wr(cmd_wr), .cmd_bm(cmd_bm), .intx(intx), .notify_stb(notify_stb),
        .notify_idx(notify_idx), .dev_reset(dev_reset)
    );

    // Reference model state
    logic [31:0] m_gf;
    int          m_qsel;
    logic [31:0] m_pg [NQ];
    logic [15:0] m_vec [NQ];
    logic [15:0] m_cv;
    logic [7:0]  m_st, m_isr;
    bit          m_bug;

    task automatic m_soft();
        m_gf = '0; m_qsel = 0; m_cv = 16'hFFFF; m_st = '0; m_isr = '0;
        for (int q = 0; q < NQ; q++) begin m_pg[q] = '0; m_vec[q] = 16'hFFFF; end
    endtask

    function automatic int hdr_len();
        return msg_en ? 24 : 20;
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        if (a >= hdr_len()) return 32'hC0DE_0000 | 32'(a - hdr_len());
        case (a)
            0:  return host_feat;
            4:  return m_gf;
            8:  return m_pg[m_qsel];
            12: return 32'(64 * (m_qsel + 1));
            14: return 32'(m_qsel);
            18: return {24'h0, m_st};
            19: return {24'h0, m_isr};
            20: return {16'h0, m_cv};
            22: return {16'h0, m_vec[m_qsel]};
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read one offset; starts and ends at a falling edge.
    task automatic rd(int a, string req);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = AW'(a);
        #1;
        chk(req, acc_rdata, exp_rd(a));
        if (a >= hdr_len()) begin
            chk("R9 dev_en", 32'(dev_en), 32'd1);
            chk("R9 dev_addr", 32'(dev_addr), 32'(a - hdr_len()));
        end
        if (a == 19) m_isr = '0;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    // Write one offset and mirror it into the model.
    task automatic wr(int a, logic [31:0] d);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = AW'(a); acc_wdata = d;
        #1;
        if (a >= hdr_len()) begin
            chk("R9 dev_en write", 32'(dev_en & dev_wr), 32'd1);
            chk("R9 dev_wdata", dev_wdata, d);
        end else begin
            chk("R9 no window", 32'(dev_en), 32'd0);
        end
        @(posedge clk);
        if (a < hdr_len()) begin
            case (a)
                4:  m_gf = d[30] ? (fallback_mask & host_feat) : d;
                8:  if (d == 0) m_soft(); else m_pg[m_qsel] = d;
                14: if (d[15:0] < NQ) m_qsel = int'(d[15:0]);
                18: begin
                        m_st = d[7:0];
                        if (d[2] && !bm_en) m_bug = 1'b1;
                        if (m_st == 0) m_soft();
                    end
                20: m_cv = (d[15:0] < NVEC) ? d[15:0] : 16'hFFFF;
                22: m_vec[m_qsel] = (d[15:0] < NVEC) ? d[15:0] : 16'hFFFF;
                default: ;
            endcase
        end
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic raise_isr(logic [7:0] v);
        isr_set = v;
        @(posedge clk);
        m_isr = m_isr | v;
        @(negedge clk);
        isr_set = '0;
    endtask

    task automatic cmd_write(logic bm);
        cmd_wr = 1'b1; cmd_bm = bm;
        @(posedge clk);
        if (!bm && !m_bug) m_st = m_st & 8'hFB;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_bm = 1'b1;
    endtask

    task automatic sweep(string req);
        for (int a = 0; a < 32; a++) rd(a, req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_bug = 1'b0;
        m_soft();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 intx", 32'(intx), 0);
        chk("R1 notify_stb", 32'(notify_stb), 0);
        chk("R1 dev_reset", 32'(dev_reset), 0);
        sweep("R1 reset read plain");
        msg_en = 1'b1;
        sweep("R1 reset read msg");
        msg_en = 1'b0;

        // R2: host features read-only, guest features with fallback
        wr(0, 32'h0000_0000);
        rd(0, "R2 host ro");
        wr(4, 32'h1234_5678);
        rd(4, "R2 guest store");
        wr(4, 32'h4000_0001);
        rd(4, "R2 bad feature fallback");

        // R3 / R4: queue selection sweep with sizes and pages
        for (int v = 0; v < 8; v++) begin
            wr(14, 32'(v));
            rd(14, "R3 select");
            rd(12, "R4 size");
        end
        for (int q = 0; q < NQ; q++) begin
            wr(14, 32'(q));
            wr(8, 32'(256 + q * 3 + 1));
        end
        for (int q = NQ - 1; q >= 0; q--) begin
            wr(14, 32'(q));
            rd(8, "R4 page readback");
        end
        wr(12, 32'h0000_0005);
        rd(12, "R4 size ro");

        // R12: status keeps the low byte
        wr(18, 32'h0000_01A3);
        rd(18, "R12 status low byte");

        // R11: bus-master workaround, both orders
        wr(18, 32'h0000_0007);
        cmd_write(1'b0);
        rd(18, "R11 drv ok cleared");
        bm_en = 1'b0;
        wr(18, 32'h0000_0007);
        cmd_write(1'b0);
        rd(18, "R11 flag keeps drv ok");
        bm_en = 1'b1;

        // R7: interrupt status and legacy line
        raise_isr(8'h01);
        chk("R7 intx follows bit0", 32'(intx), 1);
        msg_en = 1'b1;
        #1;
        chk("R7 intx off in msg mode", 32'(intx), 0);
        msg_en = 1'b0;
        rd(19, "R7 isr read");
        chk("R7 intx after clear", 32'(intx), 0);
        rd(19, "R7 isr cleared");
        raise_isr(8'h06);
        chk("R7 bit0 only", 32'(intx), 0);
        rd(19, "R7 isr upper bits");

        // R6: doorbell
        wr(16, 32'h0000_0002);
        chk("R6 notify strobe", 32'(notify_stb), 1);
        chk("R6 notify idx", 32'(notify_idx), 2);
        @(negedge clk);
        chk("R6 one cycle", 32'(notify_stb), 0);
        rd(16, "R10 notify reads unmapped");

        // R8: vector bookkeeping
        msg_en = 1'b1;
        wr(14, 32'd1);
        for (int v = 0; v < 6; v++) begin
            wr(20, 32'(v));
            rd(20, "R8 config vector");
            wr(22, 32'(v + 1));
            rd(22, "R8 queue vector");
        end
        wr(14, 32'd0);
        rd(22, "R8 other queue untouched");
        sweep("R9 sweep msg");
        msg_en = 1'b0;
        wr(20, 32'h0000_0001);
        sweep("R9 sweep plain");

        // R10: unmapped writes change nothing
        for (int a = 1; a < 20; a += 2) if (a != 19) wr(a, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFF);
        wr(6, 32'hFFFF_FFFF);
        sweep("R10 unmapped");

        // R5: reset through zero page
        msg_en = 1'b1;
        raise_isr(8'h01);
        wr(8, 32'h0000_0000);
        chk("R5 dev_reset pulse", 32'(dev_reset), 1);
        @(negedge clk);
        chk("R5 dev_reset single", 32'(dev_reset), 0);
        sweep("R5 after page reset");

        // R5: reset through zero status
        msg_en = 1'b0;
        wr(14, 32'd2);
        wr(8, 32'h0000_0ABC);
        wr(4, 32'h0000_0011);
        wr(18, 32'h0000_0003);
        raise_isr(8'h01);
        chk("R5 intx before", 32'(intx), 1);
        wr(18, 32'h0000_0100);
        chk("R5 dev_reset on status", 32'(dev_reset), 1);
        chk("R5 intx after", 32'(intx), 0);
        @(negedge clk);
        chk("R5 dev_reset ends", 32'(dev_reset), 0);
        sweep("R5 after status reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule